// File: doc/BRIEF.md
# Ethernet Link Fault Handler

This block sits between a client transmitter and a 64-bit XGMII-style physical-layer interface, one column word (eight byte lanes plus eight control flags) per clock in each direction. It watches the receive stream for fault sequence ordered sets, declares and clears a local-fault and a remote-fault condition, and decides what the transmit side sends each cycle: the client's word, a Remote Fault ordered set or an idle column.

A two-bit mode input selects one of three policies at run time. In off mode, faults are reported but transmission is untouched. In unidirectional mode, a local fault fills the inter-packet gaps with Remote Fault ordered sets while packets still pass, and received remote faults do not affect the transmitter. In bidirectional mode, a local fault replaces the client stream with continuous Remote Fault ordered sets and a remote fault replaces it with idles. The client side is valid/ready: a word moves when both are high. When the handler overrides the stream it lowers ready and the client holds its word. The receive side has a valid flag only and is always accepted.

Top module: `link_fault_handler`

## Requirements
- R1: After reset, both fault outputs are 0, link-up is 1, ready is 1 and the transmit output is an idle column (every byte 0x07, all control flags set).
- R2: A received column counts as a fault ordered set only when control flag 0 is set, flags 1 to 3 are clear, byte 0 is 0x9C, bytes 1 and 2 are 0x00 and byte 3 is 0x01 (local) or 0x02 (remote). Any other column, including one that differs in a single byte or flag, is not counted.
- R3: A fault of one type is declared on the clock edge that takes the 4th ordered set of that type, provided each came fewer than 128 valid columns after the one before it. A spacing of 128 or more columns restarts the count at one.
- R4: A declared fault clears on the edge that takes the 128th consecutive valid column without an ordered set of that type.
- R5: Receive columns with the valid flag low are neither counted as ordered sets nor as gap columns.
- R6: Link-up is 1 exactly when neither fault is declared.
- R7: In off mode (code 00), and with the reserved code 11, ready stays 1 and the client word (or idle when valid is low) is transmitted whatever the fault state.
- R8: In bidirectional mode (code 10), while a local fault is declared and no packet is open, ready is 0 and every transmitted column is a Remote Fault ordered set (0x9C,0x00,0x00,0x02 in lanes 0 to 3 and again in lanes 4 to 7, control 0x11).
- R9: In bidirectional mode, with a remote fault but no local fault and no packet open, ready is 0 and idles are sent. A local fault takes priority over a remote fault.
- R10: A packet is open from an accepted word with a start character (0xFB with control flag 0) until an accepted word with a terminate character (0xFD with its control flag) in any lane. In bidirectional mode, a packet already open runs to its end before the override begins.
- R11: In unidirectional mode (code 01), during a local fault, ready stays 1. A gap column (no packet open and the offered word is not a start) is replaced by a Remote Fault ordered set, and packets pass unchanged.
- R12: In unidirectional mode, a remote fault alone leaves the transmitted stream equal to the client stream.
- R13: The transmit output is registered. The column chosen in a cycle appears after the next rising edge, and an idle column is sent when the client offers nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mode | input | 2 | 00 off, 01 unidirectional, 10 bidirectional, 11 treated as off |
| rx_valid | input | 1 | Receive column present this cycle |
| rx_d | input | 64 | Receive data, lane 0 in bits 7:0 |
| rx_c | input | 8 | Receive control flag per lane |
| cl_valid | input | 1 | Client offers a transmit word |
| cl_ready | output | 1 | Handler takes the client word this cycle |
| cl_d | input | 64 | Client transmit data |
| cl_c | input | 8 | Client transmit control flags |
| tx_d | output | 64 | Transmit data to the physical layer |
| tx_c | output | 8 | Transmit control flags |
| st_local_fault | output | 1 | Local fault declared |
| st_remote_fault | output | 1 | Remote fault declared |
| st_link_up | output | 1 | No fault declared |

## Verification
The hardest case to reach is a fault that is declared while a client packet is open in bidirectional mode. The handler must let that packet finish and only then lower ready, so the fault edge has to land between a start and a terminate. The stimulus streams random ordered-set bursts of each type, with random valid gaps, while the client sends random packets of random length. This makes fault edges fall inside packets many times in every mode. Directed column sequences cover the exact 127 and 128 column spacing limits and the near-miss encodings.

// File: rtl/lfh_pkg.sv
package lfh_pkg;
  typedef enum logic [1:0] {
    MODE_OFF   = 2'b00,
    MODE_UNI   = 2'b01,
    MODE_BIDIR = 2'b10,
    MODE_RSVD  = 2'b11
  } lfh_mode_e;

  typedef enum logic [1:0] {
    SEL_CLIENT = 2'd0,
    SEL_IDLE   = 2'd1,
    SEL_RFSEQ  = 2'd2
  } lfh_sel_e;

  localparam logic [7:0] CH_SEQ   = 8'h9C;
  localparam logic [7:0] CH_IDLE  = 8'h07;
  localparam logic [7:0] CH_START = 8'hFB;
  localparam logic [7:0] CH_TERM  = 8'hFD;
  localparam logic [7:0] CODE_LOCAL  = 8'h01;
  localparam logic [7:0] CODE_REMOTE = 8'h02;
endpackage

// File: rtl/lf_seq_detect.sv
module lf_seq_detect
  import lfh_pkg::*;
#(
  parameter int         LANES    = 8,
  parameter logic [7:0] SEQ_CODE = 8'h01,
  parameter int         OS_NEED  = 4,
  parameter int         GAP_COLS = 128
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               col_valid,
  input  logic [8*LANES-1:0] col_d,
  input  logic [LANES-1:0]   col_c,
  output logic               fault
);
  localparam int GW = $clog2(GAP_COLS + 1);
  localparam int NW = $clog2(OS_NEED + 1);
  localparam logic [GW-1:0] GAP_MAX = GW'(GAP_COLS);
  localparam logic [NW-1:0] NEED    = NW'(OS_NEED);

  logic          hit;
  logic [GW-1:0] gap_q;
  logic [NW-1:0] cnt_q;
  logic [NW-1:0] cnt_inc;

  always_comb begin
    hit = col_c[0] && (col_c[3:1] == 3'b000) &&
          (col_d[7:0] == CH_SEQ) && (col_d[23:8] == 16'h0000) &&
          (col_d[31:24] == SEQ_CODE);
    if (gap_q < GAP_MAX)
      cnt_inc = (cnt_q == NEED) ? cnt_q : cnt_q + 1'b1;
    else
      cnt_inc = NW'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      gap_q <= GAP_MAX;
      cnt_q <= '0;
      fault <= 1'b0;
    end else if (col_valid) begin
      if (hit) begin
        gap_q <= '0;
        cnt_q <= cnt_inc;
        if (cnt_inc == NEED) fault <= 1'b1;
      end else if (gap_q != GAP_MAX) begin
        gap_q <= gap_q + 1'b1;
        if (gap_q == GAP_MAX - 1'b1) begin
          fault <= 1'b0;
          cnt_q <= '0;
        end
      end
    end
  end

  // R3
  fault_rise_on_hit_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(fault) |-> $past(col_valid && hit));
  // R4
  fault_fall_on_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(fault) |-> $past(col_valid && !hit));
  // R5
  idle_column_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !col_valid |=> $stable(fault));
endmodule

// File: rtl/lf_tx_select.sv
module lf_tx_select
  import lfh_pkg::*;
#(
  parameter int LANES = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [1:0]         mode,
  input  logic               lf,
  input  logic               rf,
  input  logic               cl_valid,
  output logic               cl_ready,
  input  logic [8*LANES-1:0] cl_d,
  input  logic [LANES-1:0]   cl_c,
  output logic [8*LANES-1:0] tx_d,
  output logic [LANES-1:0]   tx_c
);
  localparam int DW = 8 * LANES;

  logic [DW-1:0]    idle_d, rfs_d;
  logic [LANES-1:0] idle_c, rfs_c, term_lane;
  logic             in_pkt_q, start_w, term_w, hold, uni_gap, accept;
  lfh_sel_e         sel;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    localparam int POS = g % 4;
    assign idle_d[8*g +: 8] = CH_IDLE;
    assign idle_c[g]        = 1'b1;
    assign rfs_d[8*g +: 8]  = (POS == 0) ? CH_SEQ : (POS == 3) ? CODE_REMOTE : 8'h00;
    assign rfs_c[g]         = (POS == 0);
    assign term_lane[g]     = cl_c[g] && (cl_d[8*g +: 8] == CH_TERM);
  end

  always_comb begin
    start_w = cl_c[0] && (cl_d[7:0] == CH_START);
    term_w  = |term_lane;
    hold    = (mode == MODE_BIDIR) && (lf || rf) && !in_pkt_q;
    uni_gap = (mode == MODE_UNI) && lf && !in_pkt_q && !(cl_valid && start_w);
    if (hold)          sel = lf ? SEL_RFSEQ : SEL_IDLE;
    else if (uni_gap)  sel = SEL_RFSEQ;
    else if (cl_valid) sel = SEL_CLIENT;
    else               sel = SEL_IDLE;
    cl_ready = !hold;
    accept   = cl_valid && !hold;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_d     <= idle_d;
      tx_c     <= idle_c;
      in_pkt_q <= 1'b0;
    end else begin
      unique case (sel)
        SEL_CLIENT: begin tx_d <= cl_d;  tx_c <= cl_c;  end
        SEL_RFSEQ:  begin tx_d <= rfs_d; tx_c <= rfs_c; end
        default:    begin tx_d <= idle_d; tx_c <= idle_c; end
      endcase
      if (accept) begin
        if (term_w)       in_pkt_q <= 1'b0;
        else if (start_w) in_pkt_q <= 1'b1;
      end
    end
  end

  // R10
  open_packet_passes_chk: assert property (@(posedge clk) disable iff (rst)
    (in_pkt_q && cl_valid) |=> (tx_d == $past(cl_d) && tx_c == $past(cl_c)));
  // R8
  bidir_local_rfseq_chk: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_BIDIR && lf && !in_pkt_q) |=> (tx_d == rfs_d && tx_c == rfs_c));
  // R12
  uni_remote_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_UNI && rf && !lf && cl_valid) |=> (tx_d == $past(cl_d)));
  // R7
  off_mode_passes_chk: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_OFF && cl_valid) |=> (tx_c == $past(cl_c)));
endmodule

// File: rtl/link_fault_handler.sv
module link_fault_handler
  import lfh_pkg::*;
#(
  parameter int LANES    = 8,
  parameter int OS_NEED  = 4,
  parameter int GAP_COLS = 128
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [1:0]         mode,
  input  logic               rx_valid,
  input  logic [8*LANES-1:0] rx_d,
  input  logic [LANES-1:0]   rx_c,
  input  logic               cl_valid,
  output logic               cl_ready,
  input  logic [8*LANES-1:0] cl_d,
  input  logic [LANES-1:0]   cl_c,
  output logic [8*LANES-1:0] tx_d,
  output logic [LANES-1:0]   tx_c,
  output logic               st_local_fault,
  output logic               st_remote_fault,
  output logic               st_link_up
);
  localparam int NTYPES = 2;
  logic [NTYPES-1:0] flt;

  for (genvar t = 0; t < NTYPES; t++) begin : g_det
    lf_seq_detect #(
      .LANES   (LANES),
      .SEQ_CODE((t == 0) ? CODE_LOCAL : CODE_REMOTE),
      .OS_NEED (OS_NEED),
      .GAP_COLS(GAP_COLS)
    ) u_det (
      .clk      (clk),
      .rst      (rst),
      .col_valid(rx_valid),
      .col_d    (rx_d),
      .col_c    (rx_c),
      .fault    (flt[t])
    );
  end

  lf_tx_select #(.LANES(LANES)) u_tx (
    .clk     (clk),
    .rst     (rst),
    .mode    (mode),
    .lf      (flt[0]),
    .rf      (flt[1]),
    .cl_valid(cl_valid),
    .cl_ready(cl_ready),
    .cl_d    (cl_d),
    .cl_c    (cl_c),
    .tx_d    (tx_d),
    .tx_c    (tx_c)
  );

  assign st_local_fault  = flt[0];
  assign st_remote_fault = flt[1];
  assign st_link_up      = ~|flt;

  // R6
  link_return_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(st_link_up) |-> $past(st_local_fault || st_remote_fault));
endmodule

// File: tb/link_fault_handler_bench.sv
module link_fault_handler_bench;
  localparam int GAP  = 128;
  localparam int NEED = 4;
  localparam logic [63:0] IDLE_D = {8{8'h07}};
  localparam logic [7:0]  IDLE_C = 8'hFF;
  localparam logic [63:0] RF_D   = {8'h02, 8'h00, 8'h00, 8'h9C, 8'h02, 8'h00, 8'h00, 8'h9C};
  localparam logic [7:0]  RF_C   = 8'h11;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic [1:0]  mode = 2'b00;
  logic        rx_valid = 1'b0;
  logic [63:0] rx_d = IDLE_D;
  logic [7:0]  rx_c = IDLE_C;
  logic        cl_valid = 1'b0;
  logic        cl_ready;
  logic [63:0] cl_d = IDLE_D;
  logic [7:0]  cl_c = IDLE_C;
  logic [63:0] tx_d;
  logic [7:0]  tx_c;
  logic        st_lf, st_rf, st_up;

  link_fault_handler u_link_fault_handler (
    .clk(clk), .rst(rst), .mode(mode),
    .rx_valid(rx_valid), .rx_d(rx_d), .rx_c(rx_c),
    .cl_valid(cl_valid), .cl_ready(cl_ready), .cl_d(cl_d), .cl_c(cl_c),
    .tx_d(tx_d), .tx_c(tx_c),
    .st_local_fault(st_lf), .st_remote_fault(st_rf), .st_link_up(st_up)
  );

  int checks = 0;
  int errors = 0;
  int m_cnt[2];
  int m_gap[2];
  bit m_flt[2];
  bit m_pkt;

  function automatic bit os_hit(logic [63:0] d, logic [7:0] c, logic [7:0] code);
    return c[0] && c[3:1] == 3'b000 && d[7:0] == 8'h9C && d[15:8] == 8'h00 &&
           d[23:16] == 8'h00 && d[31:24] == code;
  endfunction
  function automatic bit w_start(logic [63:0] d, logic [7:0] c);
    return c[0] && d[7:0] == 8'hFB;
  endfunction
  function automatic bit w_term(logic [63:0] d, logic [7:0] c);
    for (int i = 0; i < 8; i++) if (c[i] && d[8*i +: 8] == 8'hFD) return 1'b1;
    return 1'b0;
  endfunction
  function automatic logic [63:0] os_word(logic [7:0] code);
    return {32'h07070707, code, 8'h00, 8'h00, 8'h9C};
  endfunction
  function automatic string tx_tag();
    if (mode == 2'b10 && m_pkt && (m_flt[0] || m_flt[1])) return "R10";
    if (mode == 2'b00 || mode == 2'b11) return "R7";
    if (mode == 2'b10 && m_flt[0]) return "R8";
    if (mode == 2'b10 && m_flt[1]) return "R9";
    if (mode == 2'b01 && m_flt[0]) return "R11";
    if (mode == 2'b01 && m_flt[1]) return "R12";
    return "R13";
  endfunction

  task automatic chk(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic cycle(input string stag);
    string tg;
    logic rdy;
    logic [63:0] nd;
    logic [7:0] nc;
    #1;
    tg  = tx_tag();
    rdy = !(mode == 2'b10 && (m_flt[0] || m_flt[1]) && !m_pkt);
    chk(tg, "cl_ready", 64'(cl_ready), 64'(rdy));
    if (mode == 2'b10 && !m_pkt && m_flt[0]) begin nd = RF_D; nc = RF_C; end
    else if (mode == 2'b10 && !m_pkt && m_flt[1]) begin nd = IDLE_D; nc = IDLE_C; end
    else if (mode == 2'b01 && m_flt[0] && !m_pkt && !(cl_valid && w_start(cl_d, cl_c))) begin
      nd = RF_D; nc = RF_C;
    end else if (cl_valid) begin nd = cl_d; nc = cl_c; end
    else begin nd = IDLE_D; nc = IDLE_C; end
    if (cl_valid && rdy) begin
      if (w_term(cl_d, cl_c)) m_pkt = 1'b0;
      else if (w_start(cl_d, cl_c)) m_pkt = 1'b1;
    end
    if (rx_valid) begin
      for (int t = 0; t < 2; t++) begin
        if (os_hit(rx_d, rx_c, (t == 0) ? 8'h01 : 8'h02)) begin
          m_cnt[t] = (m_gap[t] < GAP) ? ((m_cnt[t] < NEED) ? m_cnt[t] + 1 : NEED) : 1;
          m_gap[t] = 0;
          if (m_cnt[t] >= NEED) m_flt[t] = 1'b1;
        end else if (m_gap[t] < GAP) begin
          m_gap[t]++;
          if (m_gap[t] == GAP) begin m_flt[t] = 1'b0; m_cnt[t] = 0; end
        end
      end
    end
    @(posedge clk);
    @(negedge clk);
    chk(tg, "tx_d", tx_d, nd);
    chk(tg, "tx_c", 64'(tx_c), 64'(nc));
    chk((stag != "") ? stag : (m_flt[0] ? "R3" : "R4"), "local", 64'(st_lf), 64'(m_flt[0]));
    chk((stag != "") ? stag : (m_flt[1] ? "R3" : "R4"), "remote", 64'(st_rf), 64'(m_flt[1]));
    chk("R6", "link_up", 64'(st_up), 64'(!(m_flt[0] || m_flt[1])));
  endtask

  task automatic col(input logic [63:0] d, input logic [7:0] c, input bit v, input string stag);
    rx_d = d; rx_c = c; rx_valid = v; cl_valid = 1'b0;
    cycle(stag);
  endtask

  task automatic drive_client();
    int k;
    cl_valid = ($urandom % 100) < 85;
    if (!m_pkt) begin
      if ($urandom % 3 == 0) begin
        cl_d = {$urandom, $urandom}; cl_d[7:0] = 8'hFB; cl_c = 8'h01;
      end else begin
        cl_d = IDLE_D; cl_c = IDLE_C;
      end
    end else if ($urandom % 4 == 0) begin
      k = $urandom % 8;
      cl_d = {$urandom, $urandom}; cl_c = 8'h00;
      for (int i = 0; i < 8; i++) begin
        if (i == k) begin cl_d[8*i +: 8] = 8'hFD; cl_c[i] = 1'b1; end
        else if (i > k) begin cl_d[8*i +: 8] = 8'h07; cl_c[i] = 1'b1; end
      end
    end else begin
      cl_d = {$urandom, $urandom}; cl_c = 8'h00;
    end
  endtask

  task automatic drive_rx(input int lf_pct, input int rf_pct);
    int r;
    rx_valid = ($urandom % 10) != 0;
    r = $urandom % 100;
    rx_c = 8'hF1;
    if (r < lf_pct) rx_d = os_word(8'h01);
    else if (r < lf_pct + rf_pct) rx_d = os_word(8'h02);
    else if (r % 7 == 0) rx_d = os_word(8'h03);
    else begin rx_d = IDLE_D; rx_c = IDLE_C; end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL R13 watchdog actual=timeout expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd2024);
    for (int t = 0; t < 2; t++) begin m_cnt[t] = 0; m_gap[t] = GAP; m_flt[t] = 1'b0; end
    m_pkt = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    chk("R1", "tx_d", tx_d, IDLE_D);
    chk("R1", "tx_c", 64'(tx_c), 64'(IDLE_C));
    chk("R1", "faults", 64'({st_lf, st_rf}), 64'(0));
    chk("R1", "link_up", 64'(st_up), 64'(1));
    chk("R1", "cl_ready", 64'(cl_ready), 64'(1));
    rst = 1'b0;

    // R2 near misses
    repeat (4) col(os_word(8'h03), 8'hF1, 1'b1, "R2");
    repeat (4) col(os_word(8'h01), 8'hF3, 1'b1, "R2");
    repeat (4) col(os_word(8'h01) | 64'h0000_0000_0000_1000, 8'hF1, 1'b1, "R2");
    // R3 spacing limits
    repeat (3) col(os_word(8'h01), 8'hF1, 1'b1, "R3");
    repeat (GAP) col(IDLE_D, IDLE_C, 1'b1, "R3");
    col(os_word(8'h01), 8'hF1, 1'b1, "R3");
    repeat (3) begin
      repeat (GAP - 1) col(IDLE_D, IDLE_C, 1'b1, "R3");
      col(os_word(8'h01), 8'hF1, 1'b1, "R3");
    end
    // R5 invalid columns
    repeat (300) col(IDLE_D, IDLE_C, 1'b0, "R5");
    // R4 clear boundary
    repeat (GAP - 1) col(IDLE_D, IDLE_C, 1'b1, "R4");
    col(IDLE_D, IDLE_C, 1'b1, "R4");
    repeat (4) col(os_word(8'h02), 8'hF1, 1'b1, "R3");
    repeat (GAP) col(IDLE_D, IDLE_C, 1'b1, "R4");

    // random mixed traffic across modes and fault patterns
    for (int md = 0; md < 4; md++) begin
      for (int fp = 0; fp < 4; fp++) begin
        mode = 2'(md);
        repeat (160) begin
          drive_client();
          case (fp)
            0: drive_rx(30, 0);
            1: drive_rx(0, 30);
            2: drive_rx(20, 20);
            default: drive_rx(2, 2);
          endcase
          cycle("");
        end
        repeat (GAP + 20) begin
          drive_client();
          drive_rx(0, 0);
          cycle("");
        end
      end
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule